// File: doc/BRIEF.md
# Stream Frame Checker

This block checks test frames that arrive on a 64-bit AXI4-Stream slave port. Every frame opens with two fixed 64-bit header words. These are followed by zero or more data beats and then a closing beat whose lower 32 bits carry a CRC. The checker walks a registered phase machine through the two headers and then the body. On each body beat it compares the four 16-bit lanes against an arithmetic column pattern and folds all eight bytes into a running CRC-32. On the closing beat it compares the carried CRC with the computed one. A matching frame bumps an 11-bit good-frame counter once, and a mismatch raises an error flag.

The sink never applies back-pressure: `s_tready` is tied high. A beat is consumed on every rising clock edge where `s_tvalid` is 1, so the upstream source alone sets the pace. Control (`start`) and status (phase, flags, counters) are plain registered pins. A synchronous, active-high reset returns the block to idle. After a pulse on `start` it checks frames back to back until the next reset.

Top module: `stream_frame_checker`

## Requirements
- R1: While `rst` is 1 at a clock edge, the block goes to phase 0 (idle), and `good_cnt`, `col_ok_cnt`, `crc_err` and `hdr_seen` all become 0. `s_tready` is 1 at all times.
- R2: In idle, stream beats have no effect. A `start` pulse moves the phase to 1 (awaiting the first header).
- R3: In phase 1, the block moves to phase 2 only on a beat with `s_tvalid`=1, `s_tkeep`=0xFF and `s_tdata` equal to the first header word. Any other cycle leaves the phase at 1.
- R4: In phase 2, a full-lane beat equal to the second header word moves the block to phase 3 (body) and sets `hdr_seen`. Any other cycle leaves the phase at 2.
- R5: In the body, cycles with `s_tvalid`=0 change nothing, whatever `s_tlast` and `s_tdata` hold.
- R6: For body beat n (counted from 0, closing beat excluded), 16-bit lane k (bits 16k+15..16k) must equal 4*(n+1)-11+k modulo 2^16. `col_ok_cnt` counts the beats whose four lanes all match.
- R7: `col_ok_cnt` and the column index are cleared on every clock edge where the phase is 1.
- R8: The CRC is the reflected CRC-32 (polynomial 0x04C11DB7, initial value and final XOR 0xFFFFFFFF). It covers every non-closing body beat, lane 0 byte first. When bits 31..0 of the closing beat equal it, `good_cnt` increments by exactly one and `crc_err` clears.
- R9: On a CRC mismatch at the closing beat, `crc_err` is set and `good_cnt` holds its value.
- R10: After the closing beat the phase returns to 1 and `hdr_seen` clears.
- R11: `bytes_left` is loaded with FRAME_BYTES (default 64) while in phase 1. It drops by 8 when the second header is accepted and on each body beat, and stops at 0.
- R12: `good_cnt` is 11 bits wide and wraps from 2047 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leaves idle and begins header search |
| s_tdata | input | 64 | Stream data |
| s_tkeep | input | 8 | Stream byte-lane valid mask |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Marks the closing CRC beat |
| s_tready | output | 1 | Always 1, no back-pressure |
| phase | output | 2 | 0 idle, 1 first header, 2 second header, 3 body |
| hdr_seen | output | 1 | Both headers matched, frame in progress |
| crc_err | output | 1 | Last closing beat carried a wrong CRC |
| good_cnt | output | 11 | Frames with a matching CRC |
| col_ok_cnt | output | 16 | Body beats matching the column pattern |
| bytes_left | output | 16 | Bytes remaining in the current frame |

## Verification
The hardest state to reach is the wrap of the good-frame counter. Getting there takes 2048 CRC-clean frames, so the stimulus sends minimal frames: two headers followed directly by a closing beat carrying the CRC of an empty body, which is zero. A second awkward case is a frame that passes its CRC while failing the column pattern. The bench computes the CRC over the words it actually sends, including a deliberately corrupted column, so the two checks can be told apart. Idle cycles with `s_tlast` and junk data are placed inside frames to show they are ignored.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HDR_A = 2'd1,
    PH_HDR_B = 2'd2,
    PH_BODY  = 2'd3
  } phase_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
endpackage

// File: rtl/sfc_crc_acc.sv
// Running reflected CRC-32 over whole beats, byte lane 0 first.
module sfc_crc_acc #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed,
  input  logic              update,
  input  logic [DATA_W-1:0] data,
  output logic [31:0]       crc_final
);
  import sfc_pkg::*;
  localparam int NBYTES = DATA_W / 8;

  logic [31:0] crc_q, crc_next;

  always_comb begin
    crc_next = crc_q;
    for (int b = 0; b < NBYTES; b++) begin
      crc_next = crc_next ^ {24'h0, data[8*b +: 8]};
      for (int i = 0; i < 8; i++)
        crc_next = crc_next[0] ? ((crc_next >> 1) ^ CRC_POLY_REFL) : (crc_next >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || seed) crc_q <= CRC_SEED;
    else if (update) crc_q <= crc_next;
  end

  assign crc_final = ~crc_q;
endmodule

// File: rtl/sfc_col_check.sv
// Arithmetic column pattern check: lane k of column n = STRIDE*(n+1) - OFFSET + k.
module sfc_col_check #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  parameter int CNT_W  = 16,
  parameter int STRIDE = 4,
  parameter int OFFSET = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat,
  input  logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  ok_cnt
);
  localparam int LANES = DATA_W / LANE_W;

  logic [LANE_W-1:0] col_q;
  logic [LANE_W-1:0] base;
  logic [LANES-1:0]  lane_hit;

  assign base = LANE_W'(STRIDE) * (col_q + LANE_W'(1)) - LANE_W'(OFFSET);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_hit[k] = (data[k*LANE_W +: LANE_W] == base + LANE_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      col_q  <= '0;
      ok_cnt <= '0;
    end else if (beat) begin
      col_q <= col_q + LANE_W'(1);
      if (&lane_hit) ok_cnt <= ok_cnt + CNT_W'(1);
    end
  end

  // R7: the count is zero after any clearing edge
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ok_cnt == '0));

  // R6: one beat adds at most one to the count
  a_r6_step_one: assert property (@(posedge clk) disable iff (rst)
    (beat && !clear) |=> (ok_cnt == $past(ok_cnt) || ok_cnt == $past(ok_cnt) + CNT_W'(1)));
endmodule

// File: rtl/stream_frame_checker.sv
module stream_frame_checker #(
  parameter int          DATA_W      = 64,
  parameter int          CNT_W       = 11,
  parameter int          COL_CNT_W   = 16,
  parameter int          LEFT_W      = 16,
  parameter int          FRAME_BYTES = 64,
  parameter logic [63:0] HDR_A_WORD  = 64'hA5A5_0001_5A5A_0001,
  parameter logic [63:0] HDR_B_WORD  = 64'hC3C3_0002_3C3C_0002
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DATA_W-1:0]    s_tdata,
  input  logic [DATA_W/8-1:0]  s_tkeep,
  input  logic                 s_tvalid,
  input  logic                 s_tlast,
  output logic                 s_tready,
  output logic [1:0]           phase,
  output logic                 hdr_seen,
  output logic                 crc_err,
  output logic [CNT_W-1:0]     good_cnt,
  output logic [COL_CNT_W-1:0] col_ok_cnt,
  output logic [LEFT_W-1:0]    bytes_left
);
  import sfc_pkg::*;
  localparam int KEEP_W     = DATA_W / 8;
  localparam int BEAT_BYTES = DATA_W / 8;

  phase_t             ph_q, ph_d;
  logic               hdr_d, err_d;
  logic [CNT_W-1:0]   good_d;
  logic [LEFT_W-1:0]  left_d, left_dec;
  logic               full_beat, crc_seed, crc_upd, col_beat, col_clr;
  logic [31:0]        crc_calc;
  logic               armed_q;

  assign s_tready  = 1'b1;
  assign full_beat = s_tvalid && (s_tkeep == {KEEP_W{1'b1}});
  assign left_dec  = (bytes_left >= LEFT_W'(BEAT_BYTES)) ? bytes_left - LEFT_W'(BEAT_BYTES) : '0;
  assign col_clr   = (ph_q == PH_HDR_A);

  sfc_crc_acc #(.DATA_W(DATA_W)) i_crc (
    .clk(clk), .rst(rst), .seed(crc_seed), .update(crc_upd),
    .data(s_tdata), .crc_final(crc_calc)
  );

  sfc_col_check #(.DATA_W(DATA_W), .CNT_W(COL_CNT_W)) i_col (
    .clk(clk), .rst(rst), .clear(col_clr), .beat(col_beat),
    .data(s_tdata), .ok_cnt(col_ok_cnt)
  );

  always_comb begin
    ph_d     = ph_q;
    hdr_d    = hdr_seen;
    err_d    = crc_err;
    good_d   = good_cnt;
    left_d   = bytes_left;
    crc_seed = 1'b0;
    crc_upd  = 1'b0;
    col_beat = 1'b0;
    case (ph_q)
      PH_IDLE: if (start) ph_d = PH_HDR_A;
      PH_HDR_A: begin
        left_d = LEFT_W'(FRAME_BYTES);
        if (full_beat && s_tdata == HDR_A_WORD) ph_d = PH_HDR_B;
      end
      PH_HDR_B: begin
        if (full_beat && s_tdata == HDR_B_WORD) begin
          ph_d     = PH_BODY;
          hdr_d    = 1'b1;
          crc_seed = 1'b1;
          left_d   = left_dec;
        end
      end
      PH_BODY: begin
        if (s_tvalid) begin
          left_d = left_dec;
          if (s_tlast) begin
            ph_d  = PH_HDR_A;
            hdr_d = 1'b0;
            if (s_tdata[31:0] == crc_calc) begin
              good_d = good_cnt + CNT_W'(1);
              err_d  = 1'b0;
            end else begin
              err_d  = 1'b1;
            end
          end else begin
            crc_upd  = 1'b1;
            col_beat = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q       <= PH_IDLE;
      hdr_seen   <= 1'b0;
      crc_err    <= 1'b0;
      good_cnt   <= '0;
      bytes_left <= '0;
      armed_q    <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      hdr_seen   <= hdr_d;
      crc_err    <= err_d;
      good_cnt   <= good_d;
      bytes_left <= left_d;
      armed_q    <= 1'b1;
    end
  end

  assign phase = ph_q;

  // R8: the good-frame counter only ever steps by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !$stable(good_cnt) |-> (good_cnt == $past(good_cnt) + CNT_W'(1)));

  // R9: after a closing beat the error flag is set exactly when the count held
  a_r9_err_vs_count: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_BODY && s_tvalid && s_tlast) |=> (crc_err == (good_cnt == $past(good_cnt))));

  // R3: without a valid beat the first-header phase holds
  a_r3_hold_hdr_a: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_HDR_A && !s_tvalid) |=> (phase == 2'd1));

  // R10: closing beat returns to header search with the flag down
  a_r10_return: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_BODY && s_tvalid && s_tlast) |=> (phase == 2'd1 && !hdr_seen));

  // R1: the sink never stalls
  a_r1_ready: assert property (@(posedge clk) s_tready);
endmodule

// File: tb/test_stream_frame_checker.sv
`timescale 1ns/1ps
module test_stream_frame_checker;
  localparam logic [63:0] HA = 64'hA5A5_0001_5A5A_0001;
  localparam logic [63:0] HB = 64'hC3C3_0002_3C3C_0002;
  localparam int FB = 64;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [63:0] s_tdata = '0;
  logic [7:0]  s_tkeep = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [1:0] phase;
  logic hdr_seen, crc_err;
  logic [10:0] good_cnt;
  logic [15:0] col_ok_cnt, bytes_left;

  int n_chk = 0, n_fail = 0;
  int g_exp = 0;

  always #2.5 clk = ~clk;

  stream_frame_checker i_stream_frame_checker (
    .clk(clk), .rst(rst), .start(start), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
    .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready), .phase(phase),
    .hdr_seen(hdr_seen), .crc_err(crc_err), .good_cnt(good_cnt),
    .col_ok_cnt(col_ok_cnt), .bytes_left(bytes_left)
  );

  // frame vectors: {columns, corrupted column (15 = none), flip CRC, wrong second header first}
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {4'd3, 4'd15, 1'b0, 1'b0},
    {4'd0, 4'd15, 1'b0, 1'b0},
    {4'd5, 4'd2,  1'b0, 1'b0},
    {4'd2, 4'd15, 1'b1, 1'b0},
    {4'd4, 4'd0,  1'b0, 1'b1},
    {4'd1, 4'd15, 1'b1, 1'b1},
    {4'd9, 4'd15, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c_in, input logic [63:0] w);
    logic [31:0] c = c_in;
    for (int b = 0; b < 8; b++) begin
      c ^= {24'h0, w[8*b +: 8]};
      for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [63:0] col_word(input int n);
    logic [63:0] w;
    for (int k = 0; k < 4; k++) begin
      int v = 4 * (n + 1) - 11 + k;
      w[16*k +: 16] = v[15:0];
    end
    return w;
  endfunction

  // drive at a falling edge, return at the next falling edge (one rising edge consumed)
  task automatic beat(input logic [63:0] d, input logic [7:0] keep, input logic v, input logic last);
    s_tdata = d; s_tkeep = keep; s_tvalid = v; s_tlast = last;
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; s_tkeep = '0;
  endtask

  task automatic run_frame(input int ncols, input int bad, input bit flip, input bit bmiss);
    logic [31:0] c = 32'hFFFF_FFFF;
    int ok_exp = 0;
    int left = FB;
    beat(HA, 8'hFF, 1, 0);
    if (bmiss) begin
      beat(~HB, 8'hFF, 1, 0);
      chk(phase == 2'd2, "R4 wrong second header holds", phase, 2);
    end
    beat(HB, 8'hFF, 1, 0);
    left -= 8;
    chk(phase == 2'd3 && hdr_seen, "R4 enter body", {phase, hdr_seen}, 3'b111);
    chk(bytes_left == 16'(left), "R11 after second header", bytes_left, left);
    for (int n = 0; n < ncols; n++) begin
      logic [63:0] w = col_word(n);
      if (n == bad) w ^= 64'h1; else ok_exp++;
      c = ref_crc(c, w);
      beat(w, 8'hFF, 1, 0);
      left = (left >= 8) ? left - 8 : 0;
      if (n == 0) begin
        beat(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 0, 1);
        chk(phase == 2'd3 && col_ok_cnt == 16'(ok_exp), "R5 idle cycle in body ignored", col_ok_cnt, ok_exp);
      end
    end
    beat({32'hDEAD_BEEF, ~c ^ (flip ? 32'h0000_0100 : 32'h0)}, 8'hFF, 1, 1);
    left = (left >= 8) ? left - 8 : 0;
    if (!flip) g_exp = (g_exp + 1) % 2048;
    chk(good_cnt == 11'(g_exp), flip ? "R9 count holds on mismatch" : "R8 count on match", good_cnt, g_exp);
    chk(crc_err == flip, flip ? "R9 error set" : "R8 error clear", crc_err, flip);
    chk(col_ok_cnt == 16'(ok_exp), "R6 column matches", col_ok_cnt, ok_exp);
    chk(bytes_left == 16'(left), "R11 remaining bytes", bytes_left, left);
    chk(phase == 2'd1 && !hdr_seen, "R10 back to header search", {phase, hdr_seen}, 3'b010);
  endtask

  task automatic empty_frame();
    beat(HA, 8'hFF, 1, 0);
    beat(HB, 8'hFF, 1, 0);
    beat(64'h0, 8'hFF, 1, 1);
    g_exp = (g_exp + 1) % 2048;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(phase == 2'd0 && good_cnt == 0 && col_ok_cnt == 0 && !crc_err && !hdr_seen,
        "R1 reset state", {phase, good_cnt}, 0);
    chk(s_tready == 1'b1, "R1 ready high", s_tready, 1);
    rst = 1'b0;
    @(negedge clk);
    // R2: a full frame before start is ignored
    beat(HA, 8'hFF, 1, 0);
    beat(HB, 8'hFF, 1, 0);
    beat(64'h0, 8'hFF, 1, 1);
    chk(phase == 2'd0 && good_cnt == 0 && !hdr_seen, "R2 idle ignores beats", {phase, good_cnt}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(phase == 2'd1, "R2 start leaves idle", phase, 1);
    // R3: partial lanes, wrong word, no valid
    beat(HA, 8'h7F, 1, 0);
    chk(phase == 2'd1, "R3 partial keep rejected", phase, 1);
    beat(HB, 8'hFF, 1, 0);
    chk(phase == 2'd1, "R3 wrong word rejected", phase, 1);
    beat(HA, 8'hFF, 0, 0);
    chk(phase == 2'd1, "R3 invalid beat ignored", phase, 1);
    // table walk
    for (int v = 0; v < NV; v++)
      run_frame(int'(VEC[v][9:6]), int'(VEC[v][5:2]), VEC[v][1], VEC[v][0]);
    // R7: one cycle in header search clears the column count, reloads bytes
    @(negedge clk);
    chk(col_ok_cnt == 0, "R7 column count cleared", col_ok_cnt, 0);
    chk(bytes_left == 16'(FB), "R11 reload in header search", bytes_left, FB);
    // R8: known CRC-32 of ASCII "12345678"
    beat(HA, 8'hFF, 1, 0);
    beat(HB, 8'hFF, 1, 0);
    beat(64'h3837_3635_3433_3231, 8'hFF, 1, 0);
    beat({32'h0, 32'h9AE0_DAAF}, 8'hFF, 1, 1);
    g_exp = (g_exp + 1) % 2048;
    chk(good_cnt == 11'(g_exp) && !crc_err, "R8 standard CRC vector", good_cnt, g_exp);
    // R12: wrap
    while (g_exp != 2047) empty_frame();
    chk(good_cnt == 11'd2047, "R12 counter at top", good_cnt, 2047);
    empty_frame();
    chk(good_cnt == 11'd0, "R12 counter wraps", good_cnt, 0);
    // R1: reset mid-frame
    beat(HA, 8'hFF, 1, 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk(phase == 2'd0 && good_cnt == 0 && col_ok_cnt == 0, "R1 reset mid-frame", phase, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule